// File: doc/BRIEF.md
# Station-Address PROM Access Window

This block sits at the bottom of a network controller's I/O space and owns a 16-byte station-address store. A host request carries an offset, an access size code, write data and a per-lane byte-select. Requests that land in the first 16 offsets are turned into byte operations on the store. Which widths and alignments are legal there depends on a dword-I/O mode input. Requests at higher offsets are handed to a separate register block over a valid/ready port, and that block's read response is returned to the host untouched.

Two mode inputs come from an external bus configuration register. They are sampled in the cycle a request is accepted. One selects dword-I/O mode and the other allows writes to the store. A read the window cannot serve still completes: it returns a value with every bit of the requested width set. A write the window cannot serve leaves no trace.

Top module: `sa_prom_window`

## Requirements
- R1: After reset the store holds the 6-byte MAC_ADDR parameter, byte i being MAC_ADDR[8i+7:8i], in bytes 0 to 5, and zeros in bytes 6 to 15. rd_valid is low while rst_n is low.
- R2: The size code req_size is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for undefined. With dword mode clear, a 1-byte read at any window offset (0x00 to 0x0F) returns that byte in rd_data[7:0] with the upper bits zero. rd_valid is high for exactly one cycle, in the cycle after acceptance.
- R3: With dword mode clear, a 2-byte read at an even window offset o returns {byte[o+1], byte[o]}. At an odd offset the read is rejected.
- R4: With dword mode set, only a 4-byte access at a window offset that is a multiple of 4 is served, returning {byte[o+3], byte[o+2], byte[o+1], byte[o]}. A 4-byte access with dword mode clear is rejected, and so is any other size or alignment with dword mode set.
- R5: A rejected read returns all ones across the requested width and zeros above it: 0xFF for code 0, 0xFFFF for code 1, 0xFFFFFFFF for codes 2 and 3.
- R6: A served write updates the store only while cfg_prom_we is 1. Lane k (req_wdata[8k+7:8k]) goes to byte o+k only if req_be[k] is 1. With cfg_prom_we at 0, nothing changes.
- R7: A rejected write changes no store byte, raises no downstream request and gives no read response.
- R8: At offsets 0x10 and above, 2-byte and 4-byte accesses are forwarded. ds_valid mirrors req_valid, the offset, size, write flag, data and byte-select are copied, and req_ready follows ds_ready. A forwarded access gives no local response.
- R9: At offsets 0x10 and above, code 0 and code 3 accesses are not forwarded. Reads return all ones of their width and writes are dropped.
- R10: A downstream response (ds_rsp_valid, ds_rsp_data) appears unchanged on rd_valid and rd_data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dword_mode | input | 1 | Dword-I/O mode from the bus configuration register |
| cfg_prom_we | input | 1 | Store write permission |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Byte offset in the I/O space |
| req_size | input | 2 | Size code (0:1B, 1:2B, 2:4B, 3:undefined) |
| req_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| req_be | input | 4 | Byte-select per lane |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 32 | Read data |
| ds_valid | output | 1 | Forwarded request valid |
| ds_ready | input | 1 | Downstream accepts the request |
| ds_write | output | 1 | Forwarded write flag |
| ds_offset | output | ADDR_W | Forwarded offset |
| ds_size | output | 2 | Forwarded size code |
| ds_wdata | output | 32 | Forwarded write data |
| ds_be | output | 4 | Forwarded byte-select |
| ds_rsp_valid | input | 1 | Downstream read response valid |
| ds_rsp_data | input | 32 | Downstream read response data |

## Verification
The properties watch every cycle for several things: the one-cycle response after each local read, the absence of any response after a write, forwarding of only high-offset 2-byte and 4-byte traffic with its fields mirrored, ready following the downstream side, the all-ones value of rejected reads, and the unchanged pass-through of downstream responses. Store contents are not visible at the ports, so only the bench's read-after-write sequences can show three things. These are that lane selects and the write permission gate the right bytes, that rejected writes leave the store intact, and that the reset image matches the MAC parameter.

// File: rtl/sa_prom_pkg.sv
// Package: shared encodings for the station-address window.
// Assumes: 32-bit host data path made of four byte lanes.
package sa_prom_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ROUTE_PROM   = 2'd0,
        ROUTE_DOWN   = 2'd1,
        ROUTE_REJECT = 2'd2
    } route_e;

    // All-ones value covering exactly the requested width.
    function automatic logic [DATA_W-1:0] ones_for(acc_size_e sz);
        case (sz)
            SZ_BYTE: ones_for = 32'h0000_00FF;
            SZ_HALF: ones_for = 32'h0000_FFFF;
            default: ones_for = 32'hFFFF_FFFF;
        endcase
    endfunction

    // Byte lanes touched by an access of the given size.
    function automatic logic [LANES-1:0] lanes_for(acc_size_e sz);
        case (sz)
            SZ_BYTE: lanes_for = 4'b0001;
            SZ_HALF: lanes_for = 4'b0011;
            SZ_WORD: lanes_for = 4'b1111;
            default: lanes_for = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/sa_prom_decode.sv
// Module: sa_prom_decode
// Classifies a host request as a store access, a forward to the downstream
// register port, or a reject, using the mode bit present this cycle.
// Assumes: the store window occupies offsets 0 .. PROM_BYTES-1.
module sa_prom_decode
    import sa_prom_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int PROM_BYTES = 16
) (
    input  logic [ADDR_W-1:0] offset,
    input  acc_size_e         size,
    input  logic              dword_mode,
    output route_e            route,
    output logic [LANES-1:0]  lanes
);

    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(PROM_BYTES);

    logic in_window;
    logic half_ok;
    logic word_ok;

    // Window hit and alignment terms.
    always_comb begin
        in_window = (offset < WIN_END);
        half_ok   = (size == SZ_HALF) && !offset[0];
        word_ok   = (size == SZ_WORD) && (offset[1:0] == 2'b00);
    end

    // Route selection from window, size and mode.
    always_comb begin
        route = ROUTE_REJECT;
        if (in_window) begin
            if (dword_mode) begin
                if (word_ok) route = ROUTE_PROM;
            end else if ((size == SZ_BYTE) || half_ok) begin
                route = ROUTE_PROM;
            end
        end else if ((size == SZ_HALF) || (size == SZ_WORD)) begin
            route = ROUTE_DOWN;
        end
    end

    // Lanes covered by the access.
    always_comb lanes = lanes_for(size);

endmodule

// File: rtl/sa_prom_store.sv
// Module: sa_prom_store
// Holds the station-address bytes. Four lanes read from a base index, and
// a lane-masked write is taken from the same base.
// Assumes: base plus lane stays inside the store (the decoder enforces alignment);
// the index wraps modulo the store size otherwise.
module sa_prom_store
    import sa_prom_pkg::*;
#(
    parameter int          PROM_BYTES = 16,
    parameter logic [47:0] MAC_ADDR   = 48'hEFBE_ADDE_0A52,
    localparam int         IDX_W      = $clog2(PROM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  base,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    localparam int MAC_BYTES = 6;

    logic [7:0] mem_q [PROM_BYTES];

    // Reset image of one byte: MAC first, zeros after.
    function automatic logic [7:0] init_byte(int idx);
        if (idx < MAC_BYTES) init_byte = MAC_ADDR[8*idx +: 8];
        else                 init_byte = 8'h00;
    endfunction

    // Store update: reset image or lane-masked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PROM_BYTES; i++) mem_q[i] <= init_byte(i);
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_en[l]) mem_q[base + IDX_W'(l)] <= wdata[8*l +: 8];
            end
        end
    end

    // Lane readout, one byte per lane from consecutive indices.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rd_word[8*k +: 8] = mem_q[base + IDX_W'(k)];
    end

endmodule

// File: rtl/sa_prom_resp.sv
// Module: sa_prom_resp
// Registers the local read result one cycle after acceptance and merges in
// the downstream response, which passes through without a register.
// Assumes: the host keeps one read outstanding, so the two sources never coincide.
module sa_prom_resp
    import sa_prom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              use_prom,
    input  acc_size_e         size,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] prom_word,
    input  logic              ds_rsp_valid,
    input  logic [DATA_W-1:0] ds_rsp_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] data_d;
    logic              loc_valid_q;
    logic [DATA_W-1:0] loc_data_q;

    // Widen the lane enables into a bit mask.
    for (genvar k = 0; k < LANES; k++) begin : g_mask
        assign lane_mask[8*k +: 8] = {8{lanes[k]}};
    end

    // Pick store data or the all-ones reject value.
    always_comb data_d = use_prom ? (prom_word & lane_mask) : ones_for(size);

    // One-cycle local response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_valid_q <= 1'b0;
            loc_data_q  <= '0;
        end else begin
            loc_valid_q <= fire;
            if (fire) loc_data_q <= data_d;
        end
    end

    // Merge downstream response with the local one.
    always_comb begin
        rd_valid = loc_valid_q || ds_rsp_valid;
        rd_data  = ds_rsp_valid ? ds_rsp_data : loc_data_q;
    end

endmodule

// File: rtl/sa_prom_window.sv
// Module: sa_prom_window (top)
// Register front end for a 16-byte station-address store. Low offsets decode
// into store byte operations, and high offsets forward to a downstream port.
// Assumes: mode inputs are stable within the cycle a request is accepted;
// one read outstanding at a time.
module sa_prom_window
    import sa_prom_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter int          PROM_BYTES = 16,
    parameter logic [47:0] MAC_ADDR   = 48'hEFBE_ADDE_0A52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dword_mode,
    input  logic              cfg_prom_we,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              ds_valid,
    input  logic              ds_ready,
    output logic              ds_write,
    output logic [ADDR_W-1:0] ds_offset,
    output logic [1:0]        ds_size,
    output logic [31:0]       ds_wdata,
    output logic [3:0]        ds_be,
    input  logic              ds_rsp_valid,
    input  logic [31:0]       ds_rsp_data
);

    localparam int IDX_W = $clog2(PROM_BYTES);

    acc_size_e        size_e;
    route_e           route;
    logic [LANES-1:0] lanes;
    logic             accept;
    logic             store_wr;
    logic             local_rd;
    logic [DATA_W-1:0] prom_word;

    // Size code as enum.
    always_comb size_e = acc_size_e'(req_size);

    sa_prom_decode #(
        .ADDR_W     (ADDR_W),
        .PROM_BYTES (PROM_BYTES)
    ) u_decode (
        .offset     (req_offset),
        .size       (size_e),
        .dword_mode (cfg_dword_mode),
        .route      (route),
        .lanes      (lanes)
    );

    // Handshake: only forwarded requests can be stalled.
    always_comb begin
        req_ready = (route == ROUTE_DOWN) ? ds_ready : 1'b1;
        accept    = req_valid && req_ready;
        store_wr  = accept && req_write && (route == ROUTE_PROM) && cfg_prom_we;
        local_rd  = accept && !req_write && (route != ROUTE_DOWN);
    end

    // Downstream request mirrors the host request.
    always_comb begin
        ds_valid  = req_valid && (route == ROUTE_DOWN);
        ds_write  = req_write;
        ds_offset = req_offset;
        ds_size   = req_size;
        ds_wdata  = req_wdata;
        ds_be     = req_be;
    end

    sa_prom_store #(
        .PROM_BYTES (PROM_BYTES),
        .MAC_ADDR   (MAC_ADDR)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_wr),
        .base    (req_offset[IDX_W-1:0]),
        .lane_en (lanes & req_be),
        .wdata   (req_wdata),
        .rd_word (prom_word)
    );

    sa_prom_resp u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (local_rd),
        .use_prom     (route == ROUTE_PROM),
        .size         (size_e),
        .lanes        (lanes),
        .prom_word    (prom_word),
        .ds_rsp_valid (ds_rsp_valid),
        .ds_rsp_data  (ds_rsp_data),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

endmodule

// File: rtl/sa_prom_window_chk.sv
// Module: sa_prom_window_chk
// Port-level properties of the window, attached to every instance by bind.
// Assumes: the same parameters as the top.
module sa_prom_window_chk #(
    parameter int ADDR_W     = 5,
    parameter int PROM_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dword_mode,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_offset,
    input logic [1:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              ds_valid,
    input logic              ds_ready,
    input logic [ADDR_W-1:0] ds_offset,
    input logic [31:0]       ds_wdata,
    input logic              ds_rsp_valid,
    input logic [31:0]       ds_rsp_data
);

    logic high_off;
    logic fwd_size;
    logic acc_rd_local;
    logic acc_wr;
    logic odd_half_rd;

    // Port-level classification used by the properties.
    always_comb begin
        high_off     = (req_offset >= ADDR_W'(PROM_BYTES));
        fwd_size     = (req_size == 2'd1) || (req_size == 2'd2);
        acc_rd_local = req_valid && req_ready && !req_write && !(high_off && fwd_size);
        acc_wr       = req_valid && req_ready && req_write;
        odd_half_rd  = req_valid && !req_write && !high_off && !cfg_dword_mode
                       && (req_size == 2'd1) && req_offset[0];
    end

    p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd_local |=> rd_valid);

    p_rsp_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !ds_rsp_valid) |-> $past(acc_rd_local));

    p_odd_half_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        odd_half_rd |=> (rd_data == 32'h0000_FFFF));

    p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> (!rd_valid || ds_rsp_valid));

    p_fwd_scope_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> (req_valid && high_off && fwd_size));

    p_fwd_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> (ds_offset == req_offset && ds_wdata == req_wdata));

    p_fwd_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && high_off && fwd_size) |-> (req_ready == ds_ready && ds_valid));

    p_no_fwd_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fwd_size) |-> (!ds_valid && req_ready));

    p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ds_rsp_valid |-> (rd_valid && rd_data == ds_rsp_data));

endmodule

bind sa_prom_window sa_prom_window_chk #(
    .ADDR_W     (ADDR_W),
    .PROM_BYTES (PROM_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_dword_mode (cfg_dword_mode),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_offset     (req_offset),
    .req_size       (req_size),
    .req_wdata      (req_wdata),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .ds_valid       (ds_valid),
    .ds_ready       (ds_ready),
    .ds_offset      (ds_offset),
    .ds_wdata       (ds_wdata),
    .ds_rsp_valid   (ds_rsp_valid),
    .ds_rsp_data    (ds_rsp_data)
);

// File: tb/sa_prom_window_bench.sv
// Bench for sa_prom_window: a vector table walked by one loop, then directed
// tests for reset, the downstream port and strobe length.
module sa_prom_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dword_mode = 1'b0;
    logic        cfg_prom_we = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        ds_valid;
    logic        ds_ready = 1'b0;
    logic        ds_write;
    logic [4:0]  ds_offset;
    logic [1:0]  ds_size;
    logic [31:0] ds_wdata;
    logic [3:0]  ds_be;
    logic        ds_rsp_valid = 1'b0;
    logic [31:0] ds_rsp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int ds_seen = 0;
    bit done    = 1'b0;

    localparam logic [47:0] MAC = 48'hEFBE_ADDE_0A52;

    always #2 clk = ~clk;

    sa_prom_window #(.ADDR_W(5), .PROM_BYTES(16), .MAC_ADDR(MAC)) u_sa_prom_window (
        .clk, .rst_n, .cfg_dword_mode, .cfg_prom_we, .req_valid, .req_ready,
        .req_write, .req_offset, .req_size, .req_wdata, .req_be, .rd_valid,
        .rd_data, .ds_valid, .ds_ready, .ds_write, .ds_offset, .ds_size,
        .ds_wdata, .ds_be, .ds_rsp_valid, .ds_rsp_data
    );

    // Count any forwarded-request cycles for the table phase.
    always @(posedge clk) if (ds_valid) ds_seen++;

    typedef struct packed {
        logic        wr;
        logic        dw;
        logic        we;
        logic [4:0]  off;
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{0,0,0,5'h00,2'd0,32'h0,4'h0,32'h0000_0052,8'd2},  // R2 byte 0
        '{0,0,0,5'h05,2'd0,32'h0,4'h0,32'h0000_00EF,8'd2},  // R2 byte 5
        '{0,0,0,5'h0F,2'd0,32'h0,4'h0,32'h0000_0000,8'd2},  // R2 last byte
        '{0,0,0,5'h02,2'd1,32'h0,4'h0,32'h0000_ADDE,8'd3},  // R3 even half
        '{0,0,0,5'h03,2'd1,32'h0,4'h0,32'h0000_FFFF,8'd3},  // R3 odd half rejected
        '{0,0,0,5'h00,2'd2,32'h0,4'h0,32'hFFFF_FFFF,8'd4},  // R4 word in byte mode
        '{0,1,0,5'h04,2'd2,32'h0,4'h0,32'h0000_EFBE,8'd4},  // R4 word at 4
        '{0,1,0,5'h00,2'd2,32'h0,4'h0,32'hADDE_0A52,8'd4},  // R4 word at 0
        '{0,1,0,5'h02,2'd2,32'h0,4'h0,32'hFFFF_FFFF,8'd4},  // R4 misaligned word
        '{0,1,0,5'h01,2'd0,32'h0,4'h0,32'h0000_00FF,8'd5},  // R5 byte in dword mode
        '{0,1,0,5'h00,2'd1,32'h0,4'h0,32'h0000_FFFF,8'd5},  // R5 half in dword mode
        '{0,0,0,5'h00,2'd3,32'h0,4'h0,32'hFFFF_FFFF,8'd5},  // R5 undefined size
        '{1,0,0,5'h00,2'd0,32'h11,4'h1,32'h0,8'd6},         // R6 write, not enabled
        '{0,0,0,5'h00,2'd0,32'h0,4'h0,32'h0000_0052,8'd6},  // R6 unchanged
        '{1,0,1,5'h06,2'd1,32'h3344,4'h3,32'h0,8'd6},       // R6 half write
        '{0,0,0,5'h06,2'd1,32'h0,4'h0,32'h0000_3344,8'd6},  // R6 readback
        '{1,0,1,5'h08,2'd1,32'h5566,4'h2,32'h0,8'd6},       // R6 upper lane only
        '{0,0,0,5'h08,2'd1,32'h0,4'h0,32'h0000_5500,8'd6},  // R6 readback
        '{1,1,1,5'h0C,2'd2,32'hCAFE_F00D,4'hF,32'h0,8'd6},  // R6 word write
        '{0,1,0,5'h0C,2'd2,32'h0,4'h0,32'hCAFE_F00D,8'd6},  // R6 readback
        '{1,1,1,5'h0C,2'd0,32'h77,4'h1,32'h0,8'd7},         // R7 byte write in dword mode
        '{1,0,1,5'h0D,2'd1,32'h9999,4'h3,32'h0,8'd7},       // R7 odd half write
        '{0,0,0,5'h0D,2'd0,32'h0,4'h0,32'h0000_00F0,8'd7}   // R7 byte 13 intact
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge, let it be accepted, return at the next falling edge.
    task automatic access(input logic wr, input logic dw, input logic we,
                          input logic [4:0] off, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [3:0] be);
        cfg_dword_mode = dw; cfg_prom_we = we;
        req_valid = 1'b1; req_write = wr; req_offset = off;
        req_size = sz; req_wdata = wd; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid in reset", {31'b0, rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset image, one byte at a time
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e;
            e = (i < 6) ? MAC[8*i +: 8] : 8'h00;
            access(0, 0, 0, 5'(i), 2'd0, 32'h0, 4'h0);
            check(rd_valid && rd_data == {24'h0, e}, "R1 reset image", rd_data, {24'h0, e});
        end

        // Vector table
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            string tag;
            t = TBL[v];
            tag = $sformatf("R%0d vec%0d", t.req, v);
            access(t.wr, t.dw, t.we, t.off, t.sz, t.wd, t.be);
            if (t.wr) check(!rd_valid, tag, {31'b0, rd_valid}, 32'h0);
            else      check(rd_valid && rd_data == t.exp, tag, rd_data, t.exp);
        end
        check(ds_seen == 0, "R7 no forward from window", ds_seen, 0);

        // R2: strobe lasts one cycle
        access(0, 0, 0, 5'h01, 2'd0, 32'h0, 4'h0);
        check(rd_valid && rd_data == 32'h0A, "R2 byte 1", rd_data, 32'h0A);
        @(negedge clk);
        check(!rd_valid, "R2 single-cycle strobe", {31'b0, rd_valid}, 32'h0);

        // R8: forwarded write stalled, then accepted
        ds_ready = 1'b0;
        cfg_dword_mode = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_offset = 5'h12;
        req_size = 2'd1; req_wdata = 32'h1234; req_be = 4'h3;
        #1;
        check(ds_valid && ds_write && ds_offset == 5'h12 && ds_size == 2'd1
              && ds_wdata == 32'h1234 && ds_be == 4'h3, "R8 forward fields",
              ds_wdata, 32'h1234);
        check(!req_ready, "R8 ready follows stall", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
        ds_ready = 1'b1;
        #1;
        check(req_ready, "R8 ready follows ready", {31'b0, req_ready}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(!rd_valid, "R8 no local response to write", {31'b0, rd_valid}, 32'h0);

        // R8 / R10: forwarded read, response passes through
        access(0, 0, 0, 5'h14, 2'd2, 32'h0, 4'h0);
        check(!rd_valid, "R8 no local response to forwarded read", {31'b0, rd_valid}, 32'h0);
        ds_rsp_valid = 1'b1; ds_rsp_data = 32'h600D_D00D;
        #1;
        check(rd_valid && rd_data == 32'h600D_D00D, "R10 pass-through", rd_data, 32'h600D_D00D);
        @(negedge clk);
        ds_rsp_valid = 1'b0;

        // R9: byte and undefined-size accesses at high offsets
        ds_ready = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_offset = 5'h10;
        req_size = 2'd0; req_wdata = 32'hAB; req_be = 4'h1;
        #1;
        check(!ds_valid && req_ready, "R9 byte write not forwarded", {31'b0, ds_valid}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!rd_valid, "R9 byte write silent", {31'b0, rd_valid}, 32'h0);
        access(0, 0, 0, 5'h1F, 2'd0, 32'h0, 4'h0);
        check(rd_valid && rd_data == 32'hFF, "R9 high byte read", rd_data, 32'hFF);
        access(0, 0, 0, 5'h14, 2'd3, 32'h0, 4'h0);
        check(rd_valid && rd_data == 32'hFFFF_FFFF, "R9 high undefined read",
              rd_data, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule